// File: doc/BRIEF.md
# Asynchronous DRAM Device Emulator

This block behaves like an asynchronous dynamic memory part driven by a memory controller, but it is built from synchronous logic. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable. The logic detects the edges of these strobes. A row strobe fall latches the multiplexed address as the row to open. A column strobe fall latches it as the column, and then reads or writes the word at that row and column. The data bus is split into an input port, an output port and an output-enable port, so a pad or a bench can rebuild the shared bus outside the block.

The order of the strobe edges selects the operation. If the column strobe is already low when the row strobe falls, the cycle is a refresh. A refresh uses an internal row counter in place of the address pins. A refresh can also be hidden: it runs while a read word stays on the outputs. A static mode input picks one of three behaviours. Page mode drops read data when the column strobe rises. Nibble mode runs four-word bursts with columns generated inside the block. Extended-output mode holds read data until the row closes.

Three parameters give the minimum timing, counted in sampled clock cycles: row-to-column delay, row active time and row precharge time. A sticky flag records any cycle that breaks one of these minimums.

Top module: `adram_emu`

## Requirements
- R1: After reset, dq_oe is 0, tmg_err is 0 and rfsh_row is 0.
- R2: A sampled fall of ras_n, with cas_n high, latches addr as the row. A later sampled fall of cas_n latches addr as the column. If we_n is 0 at that fall, din is written to that word. If we_n is 1, the word appears on dq_out after the same clock edge. Several columns can be accessed while the row stays open.
- R3: dq_oe is 1 only while read data is held, oe_n is 0 and we_n is 1. Raising oe_n, or lowering we_n, drops dq_oe in the same cycle without changing the stored word.
- R4: In page mode (mode = 0), dq_oe falls after the clock edge that samples cas_n rising.
- R5: A fall of ras_n sampled while cas_n is low starts a refresh. The refresh ignores addr, din and we_n, writes nothing, and increments rfsh_row by one, wrapping modulo 2^AW. A cas_n fall while ras_n is high accesses no word.
- R6: If ras_n rises and falls again while cas_n stays low after a read, dq_oe stays 1 and dq_out keeps the read word, while the second fall performs a refresh under R5.
- R7: In nibble mode (mode = 1), the first cas_n fall after the row opens takes its column from addr. The second, third and fourth falls ignore addr and add one to the low two column bits, wrapping inside the aligned group of four. The fifth fall takes addr again.
- R8: In extended-output mode (mode = 2), read data stays valid on dq_out after cas_n rises. It is dropped when ras_n rises with cas_n high. It is replaced when a new cas_n fall selects another column. dq_out never changes while ras_n is low unless a cas_n fall is sampled.
- R9: tmg_err is set when a cas_n fall on an open row comes fewer than T_RCD cycles after the ras_n fall. A fall exactly T_RCD cycles after does not set it.
- R10: tmg_err is set when ras_n is sampled low for fewer than T_RAS cycles before it rises.
- R11: tmg_err is set when ras_n is sampled high for fewer than T_RP cycles before it falls. The first fall after reset is always allowed.
- R12: tmg_err stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 page, 1 nibble, 2 extended output, 3 acts as page |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at cas_n fall |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Drive enable for dq_out |
| rfsh_row | output | AW | Refresh row counter |
| tmg_err | output | 1 | Sticky timing violation flag |

## Verification
A read-data hold and a refresh can fall in the same clock edge. This happens when ras_n falls again while cas_n has stayed low since a read. The bench provokes it by reading a word, holding cas_n low, and cycling ras_n with legal precharge and active times. At the edge that samples the second ras_n fall, the bench expects rfsh_row to step by one while dq_oe and dq_out keep the earlier word. It then expects the output to drop once cas_n rises.

// File: rtl/adram_emu.sv
module adram_emu #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 4,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] rfsh_row,
  output logic          tmg_err
);

  localparam int DEPTH = 1 << (2*AW);
  localparam logic [1:0] MD_NIB = 2'd1;
  localparam logic [1:0] MD_EDO = 2'd2;
  localparam logic [AW-1:0] LOMASK = AW'(3);

  logic          ras_q, cas_q;
  logic          row_open, rd_vld, err;
  logic [AW-1:0] row_r, col_r, rf_cnt, col_sel, nib_next;
  logic [1:0]    nib_cnt;
  logic [CW-1:0] ph_cnt;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mem [DEPTH];

  logic ras_fall, ras_rise, cas_fall, cas_rise, acc;
  logic [2*AW-1:0] idx;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign acc      = cas_fall & row_open;

  assign nib_next = (col_r & ~LOMASK) | ((col_r + AW'(1)) & LOMASK);
  assign col_sel  = (mode == MD_NIB && nib_cnt != 2'd0) ? nib_next : addr;
  assign idx      = {row_r, col_sel};

  always_ff @(posedge clk) begin
    if (acc && !we_n) mem[idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      row_open <= 1'b0;
      row_r    <= '0;
      col_r    <= '0;
      rf_cnt   <= '0;
      nib_cnt  <= '0;
      ph_cnt   <= '1;
      rd_q     <= '0;
      rd_vld   <= 1'b0;
      err      <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;

      if (ras_fall) begin
        ph_cnt  <= CW'(1);
        nib_cnt <= '0;
        if (ph_cnt < CW'(T_RP)) err <= 1'b1;
        if (!cas_n) begin
          rf_cnt <= rf_cnt + AW'(1);
        end else begin
          row_open <= 1'b1;
          row_r    <= addr;
        end
      end else if (ras_rise) begin
        ph_cnt   <= CW'(1);
        row_open <= 1'b0;
        if (ph_cnt < CW'(T_RAS)) err <= 1'b1;
      end else if (ph_cnt != '1) begin
        ph_cnt <= ph_cnt + CW'(1);
      end

      if (acc) begin
        col_r   <= col_sel;
        nib_cnt <= nib_cnt + 2'd1;
        if (ph_cnt < CW'(T_RCD)) err <= 1'b1;
        if (we_n) begin
          rd_q   <= mem[idx];
          rd_vld <= 1'b1;
        end else begin
          rd_vld <= 1'b0;
        end
      end else begin
        if (cas_rise && (mode != MD_EDO || ras_n)) rd_vld <= 1'b0;
        if (ras_rise && cas_n) rd_vld <= 1'b0;
      end
    end
  end

  assign dq_out   = rd_q;
  assign dq_oe    = rd_vld & ~oe_n & we_n;
  assign rfsh_row = rf_cnt;
  assign tmg_err  = err;

endmodule

// File: rtl/adram_emu_chk.sv
module adram_emu_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          ras_n,
  input logic          cas_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic [AW-1:0] rfsh_row,
  input logic          tmg_err
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!dq_oe && !tmg_err && rfsh_row == '0));

  assert_page_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !ras_n && $past(!cas_n) && cas_n) |=> !dq_oe);

  assert_refresh_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |=> rfsh_row == AW'($past(rfsh_row) + 1'b1));

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$fell(cas_n)) |=> $stable(dq_out));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmg_err |=> tmg_err);

endmodule

bind adram_emu adram_emu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ras_n(ras_n), .cas_n(cas_n),
  .dq_out(dq_out), .dq_oe(dq_oe), .rfsh_row(rfsh_row), .tmg_err(tmg_err)
);

// File: tb/adram_emu_test.sv
`timescale 1ns/1ps
module adram_emu_test;
  localparam int AW = 4, DW = 8, T_RCD = 3, T_RAS = 6, T_RP = 4;

  logic clk = 1'b0;
  logic rst_n, ras_n, cas_n, we_n, oe_n;
  logic [1:0] mode;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dq_out;
  logic dq_oe, tmg_err;
  logic [AW-1:0] rfsh_row;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_rf = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adram_emu #(.AW(AW), .DW(DW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out),
    .dq_oe(dq_oe), .rfsh_row(rfsh_row), .tmg_err(tmg_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 0; mode = 0; addr = 0; din = 0;
    tick(3);
    rst_n = 1; exp_rf = '0;
    tick(T_RP + 1);
  endtask

  task automatic wr(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
    addr = r; ras_n = 0; tick(T_RCD);
    addr = c; we_n = 0; din = d; cas_n = 0; tick(1);
    cas_n = 1; we_n = 1; tick(T_RAS);
    ras_n = 1; tick(T_RP);
  endtask

  task automatic rd(input logic [AW-1:0] r, input logic [AW-1:0] c,
                    output logic [DW-1:0] d, output logic oe);
    addr = r; ras_n = 0; tick(T_RCD);
    addr = c; cas_n = 0; tick(1);
    d = dq_out; oe = dq_oe;
    cas_n = 1; tick(T_RAS);
    ras_n = 1; tick(T_RP);
  endtask

  task automatic t_reset();
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 tmg_err", tmg_err, 0);
    chk("R1 rfsh_row", rfsh_row, 0);
  endtask

  task automatic t_rw();
    logic [DW-1:0] d; logic oe;
    wr(3, 9, 8'h5A); wr(3, 10, 8'hC3); wr(12, 9, 8'h11);
    rd(3, 9, d, oe);  chk("R2 oe", oe, 1); chk("R2 r3c9", d, 8'h5A);
    rd(12, 9, d, oe); chk("R2 r12c9", d, 8'h11);
    addr = 3; ras_n = 0; tick(T_RCD);
    addr = 10; cas_n = 0; tick(1); chk("R2 page c10", dq_out, 8'hC3);
    cas_n = 1; tick(1);
    addr = 9; cas_n = 0; tick(1); chk("R2 page c9", dq_out, 8'h5A);
    cas_n = 1; tick(T_RAS); ras_n = 1; tick(T_RP);
    chk("R9 no error at exact delay", tmg_err, 0);
  endtask

  task automatic t_oe();
    addr = 3; ras_n = 0; tick(T_RCD);
    addr = 9; cas_n = 0; tick(1);
    chk("R3 driven", dq_oe, 1);
    oe_n = 1; #1; chk("R3 oe_n high", dq_oe, 0);
    oe_n = 0; we_n = 0; #1; chk("R3 we_n low", dq_oe, 0);
    we_n = 1; #1; chk("R3 restored", dq_oe, 1); chk("R3 data kept", dq_out, 8'h5A);
    cas_n = 1; tick(1); chk("R4 page drop", dq_oe, 0);
    tick(T_RAS); ras_n = 1; tick(T_RP);
  endtask

  task automatic t_nib();
    for (int c = 4; c < 8; c++) wr(2, AW'(c), 8'(8'h40 + c));
    wr(2, 8, 8'h88);
    mode = 1;
    addr = 2; ras_n = 0; tick(T_RCD);
    addr = 5; cas_n = 0; tick(1); chk("R7 first", dq_out, 8'h45);
    cas_n = 1; addr = 15; tick(1);
    cas_n = 0; tick(1); chk("R7 second", dq_out, 8'h46);
    cas_n = 1; addr = 0; tick(1);
    cas_n = 0; tick(1); chk("R7 third", dq_out, 8'h47);
    cas_n = 1; addr = 13; tick(1);
    cas_n = 0; tick(1); chk("R7 fourth wraps", dq_out, 8'h44);
    cas_n = 1; addr = 8; tick(1);
    cas_n = 0; tick(1); chk("R7 fifth from pins", dq_out, 8'h88);
    cas_n = 1; tick(T_RAS); ras_n = 1; tick(T_RP);
    mode = 0;
  endtask

  task automatic t_edo();
    mode = 2;
    addr = 3; ras_n = 0; tick(T_RCD);
    addr = 9; cas_n = 0; tick(1);
    cas_n = 1; tick(1);
    chk("R8 held oe", dq_oe, 1); chk("R8 held data", dq_out, 8'h5A);
    addr = 10; cas_n = 0; tick(1); chk("R8 new column", dq_out, 8'hC3);
    cas_n = 1; tick(T_RAS); chk("R8 still held", dq_oe, 1);
    ras_n = 1; tick(1); chk("R8 dropped at row close", dq_oe, 0);
    tick(T_RP);
    mode = 0;
  endtask

  task automatic t_cbr();
    logic [DW-1:0] d; logic oe;
    we_n = 0; din = 8'hFF; addr = 3; cas_n = 0; tick(1);
    addr = 9; ras_n = 0; tick(1);
    exp_rf = exp_rf + 1'b1;
    chk("R5 counter step", rfsh_row, exp_rf);
    chk("R5 no output", dq_oe, 0);
    tick(T_RAS); ras_n = 1; cas_n = 1; we_n = 1; tick(T_RP);
    rd(3, 9, d, oe); chk("R5 data untouched", d, 8'h5A);
    for (int i = 0; i < (1 << AW); i++) begin
      cas_n = 0; tick(1); ras_n = 0; tick(1);
      tick(T_RAS); ras_n = 1; cas_n = 1; tick(T_RP);
    end
    chk("R5 counter wraps", rfsh_row, exp_rf);
    chk("R5 no error", tmg_err, 0);
  endtask

  task automatic t_hidden();
    addr = 12; ras_n = 0; tick(T_RCD);
    addr = 9; cas_n = 0; tick(1);
    tick(T_RAS); ras_n = 1; tick(1);
    chk("R6 kept in gap", dq_oe, 1);
    tick(T_RP); addr = 7; ras_n = 0; tick(1);
    exp_rf = exp_rf + 1'b1;
    chk("R6 refresh step", rfsh_row, exp_rf);
    chk("R6 oe kept", dq_oe, 1); chk("R6 data kept", dq_out, 8'h11);
    tick(T_RAS); ras_n = 1; tick(1); cas_n = 1; tick(1);
    chk("R6 drop on cas rise", dq_oe, 0);
    tick(T_RP);
    chk("R6 no error", tmg_err, 0);
  endtask

  task automatic t_trcd();
    do_reset();
    addr = 1; ras_n = 0; tick(1);
    cas_n = 0; tick(1); chk("R9 early cas", tmg_err, 1);
    cas_n = 1; tick(T_RAS); ras_n = 1; tick(T_RP);
    chk("R12 sticky", tmg_err, 1);
    do_reset(); chk("R12 cleared by reset", tmg_err, 0);
  endtask

  task automatic t_tras();
    do_reset();
    ras_n = 0; tick(T_RAS - 1); ras_n = 1;
    chk("R10 before rise", tmg_err, 0);
    tick(1); chk("R10 short active", tmg_err, 1);
    do_reset();
    ras_n = 0; tick(T_RAS); ras_n = 1; tick(1);
    chk("R10 exact active ok", tmg_err, 0);
    tick(T_RP);
  endtask

  task automatic t_trp();
    do_reset();
    ras_n = 0; tick(T_RAS); ras_n = 1; tick(T_RP - 1);
    chk("R11 before fall", tmg_err, 0);
    ras_n = 0; tick(1); chk("R11 short precharge", tmg_err, 1);
    do_reset();
    ras_n = 0; tick(T_RAS); ras_n = 1; tick(T_RP);
    ras_n = 0; tick(1); chk("R11 exact precharge ok", tmg_err, 0);
    tick(T_RAS); ras_n = 1; tick(T_RP);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_rw();
    t_oe();
    t_nib();
    t_edo();
    t_cbr();
    t_hidden();
    t_trcd();
    t_tras();
    t_trp();
    finish_run();
  end
endmodule